// File: doc/BRIEF.md
# Cascaded Dual 16-bit Timer

This block holds two 16-bit general-purpose counters that share one clock domain and count a tick that fires on every fourth system clock. Each counter has three registers: a mode/control word, the current count and a terminal (max-compare) value. The high counter can take its steps from the terminal event of the low counter instead of from the tick. The pair then forms a 32-bit free-running time base. The high half steps on the very edge at which the low half wraps.

Software reaches the six registers through a simple write strobe and a combinational read port. The enable bit in each control word is guarded: it changes only on a control write that also sets the permit bit in the same word. A mode change therefore never starts or stops a counter by accident. A terminal value of zero selects the longest period, 65536 steps. A counter can run in continuous mode, where it wraps, or in one-shot mode, where it halts at its terminal value and drops its own enable.

Top module: `dual_cascade_timer`

## Requirements
- R1: After reset every register of both counters reads 0, including during reset.
- R2: A control write (register index 0) always stores bit 0 (continuous), bit 3 (cascade select) and bit 4 (retrigger flag). Bit 15 (enable) is stored only when bit 14 (permit) is set in the same write. Bit 14 always reads 0.
- R3: A divider free-running from reset produces a tick on every fourth clock edge, the first at the fourth edge after reset release. An enabled counter that is not cascaded advances by one on each tick.
- R4: In continuous mode an enabled counter at its terminal value (max-compare minus one) returns to 0 on its next step.
- R5: A max-compare of 0 makes the terminal value 65535, giving a 65536-step period.
- R6: With the cascade select set, the high counter (counter 1) steps exactly on the edges where the enabled low counter (counter 0) steps from its terminal value, and at no other edge.
- R7: In one-shot mode (bit 0 clear) a counter that steps at its terminal value holds that value and clears its own enable.
- R8: A write to a count register (index 1) loads the written value, so writing 0 clears it. The write takes precedence over a step in the same cycle. A write to a max-compare register (index 2) loads it.
- R9: The cascade select bit of counter 0 is stored and read back but does not change its counting; it still advances once per tick.
- R10: Address bit 2 selects the counter and bits 1:0 select the register. Index 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 3 | Bit 2 selects the counter; bits 1:0 select control, count, max-compare or none |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read of the addressed register |

## Verification
A read is combinational, so it reflects the registers as they stand in the same cycle. A write becomes visible on the read port in the cycle after the edge that takes it. A count changes only on tick edges, the fourth edge after reset release and every fourth edge after that. A cascaded high counter changes on the same edge as the wrap of the low counter. The bench keeps a behavioural model that is updated at each rising edge from the inputs held since the previous falling edge. It compares the addressed register one time unit after every falling edge, so each write and each step is checked in the first cycle it is due, and in every cycle after that.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int TMR_W     = 16;
  localparam int NUM_TMR   = 2;
  localparam int DIV_RATIO = 4;
  localparam int SEL_W     = $clog2(NUM_TMR);
  localparam int ADDR_W    = SEL_W + 2;

  localparam int CONT_BIT   = 0;
  localparam int PRESC_BIT  = 3;
  localparam int RETRIG_BIT = 4;
  localparam int PERMIT_BIT = TMR_W - 2;
  localparam int EN_BIT     = TMR_W - 1;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_CNT  = 2'd1,
    REG_MAX  = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic en;
    logic retrig;
    logic presc;
    logic cont;
  } tmrCtl_t;

  typedef struct packed {
    logic [NUM_TMR-1:0] ldCnt;
    logic [NUM_TMR-1:0] ldMax;
    logic [NUM_TMR-1:0] adv;
    logic [NUM_TMR-1:0] clr;
    logic [TMR_W-1:0]   data;
  } dpStrobe_t;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [TMR_W-1:0]             wrData,
  input  logic [NUM_TMR-1:0]           atLast,
  output dpStrobe_t                    strb,
  output tmrCtl_t [NUM_TMR-1:0]        ctlQ,
  output logic [NUM_TMR-1:0]           stepQ,
  output logic                         tick
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic [DIV_W-1:0]     divCnt;
  logic [SEL_W-1:0]     tmrSel;
  regSel_e              regSel;
  tmrCtl_t [NUM_TMR-1:0] ctlR;
  logic [NUM_TMR-1:0]   step, ctlHit, ldCntV, ldMaxV, advV, clrV, termV;

  assign tmrSel = addr[ADDR_W-1:2];
  assign regSel = regSel_e'(addr[1:0]);
  assign tick   = (divCnt == DIV_W'(DIV_RATIO - 1));

  // quarter-rate tick enable, free-running from reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      logic selHit;
      assign selHit = wrEn && (tmrSel == SEL_W'(gi));
      assign ctlHit[gi] = selHit && (regSel == REG_CTL);
      assign ldCntV[gi] = selHit && (regSel == REG_CNT);
      assign ldMaxV[gi] = selHit && (regSel == REG_MAX);

      if (gi == 0) begin : g_base
        // the lowest counter has no cascade source: always tick-driven
        assign step[gi] = ctlR[gi].en && tick;
      end else begin : g_casc
        logic srcEv;
        assign srcEv    = ctlR[gi].presc ? (step[gi-1] && atLast[gi-1]) : tick;
        assign step[gi] = ctlR[gi].en && srcEv;
      end

      assign termV[gi] = step[gi] && atLast[gi];
      assign advV[gi]  = step[gi] && !atLast[gi];
      assign clrV[gi]  = termV[gi] && ctlR[gi].cont;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlR <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (ctlHit[i]) begin
          ctlR[i].cont   <= wrData[CONT_BIT];
          ctlR[i].presc  <= wrData[PRESC_BIT];
          ctlR[i].retrig <= wrData[RETRIG_BIT];
        end
        if (ctlHit[i] && wrData[PERMIT_BIT])
          ctlR[i].en <= wrData[EN_BIT];
        else if (termV[i] && !ctlR[i].cont)
          ctlR[i].en <= 1'b0;
      end
    end
  end

  assign strb  = '{ldCnt: ldCntV, ldMax: ldMaxV, adv: advV, clr: clrV, data: wrData};
  assign ctlQ  = ctlR;
  assign stepQ = step;
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strb,
  output logic [NUM_TMR-1:0][TMR_W-1:0]     cntQ,
  output logic [NUM_TMR-1:0][TMR_W-1:0]     maxQ,
  output logic [NUM_TMR-1:0]                atLast
);
  logic [NUM_TMR-1:0][TMR_W-1:0] cntR, maxR;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TMR; gi++) begin : g_last
      logic [TMR_W-1:0] lastVal;
      // zero max-compare selects the full-range period
      assign lastVal    = (maxR[gi] == '0) ? '1 : (maxR[gi] - 1'b1);
      assign atLast[gi] = (cntR[gi] == lastVal);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntR <= '0;
      maxR <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (strb.ldCnt[i])    cntR[i] <= strb.data;
        else if (strb.clr[i]) cntR[i] <= '0;
        else if (strb.adv[i]) cntR[i] <= cntR[i] + 1'b1;
        if (strb.ldMax[i])    maxR[i] <= strb.data;
      end
    end
  end

  assign cntQ = cntR;
  assign maxQ = maxR;
endmodule

// File: rtl/dual_cascade_timer.sv
module dual_cascade_timer
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMR_W-1:0]  wrData,
  output logic [TMR_W-1:0]  rdData
);
  dpStrobe_t                     strb;
  tmrCtl_t [NUM_TMR-1:0]         ctlQ;
  logic [NUM_TMR-1:0][TMR_W-1:0] cntQ, maxQ;
  logic [NUM_TMR-1:0]            atLast, stepQ, enVec, contVec;
  logic                          tick;
  logic [SEL_W-1:0]              rdSel;

  dct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .atLast(atLast), .strb(strb), .ctlQ(ctlQ), .stepQ(stepQ), .tick(tick)
  );

  dct_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntQ(cntQ), .maxQ(maxQ), .atLast(atLast)
  );

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      enVec[i]   = ctlQ[i].en;
      contVec[i] = ctlQ[i].cont;
    end
  end

  assign rdSel = addr[ADDR_W-1:2];

  always_comb begin
    rdData = '0;
    case (regSel_e'(addr[1:0]))
      REG_CTL: begin
        rdData[EN_BIT]     = ctlQ[rdSel].en;
        rdData[RETRIG_BIT] = ctlQ[rdSel].retrig;
        rdData[PRESC_BIT]  = ctlQ[rdSel].presc;
        rdData[CONT_BIT]   = ctlQ[rdSel].cont;
      end
      REG_CNT: rdData = cntQ[rdSel];
      REG_MAX: rdData = maxQ[rdSel];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_cascade_timer_chk.sv
module dual_cascade_timer_chk
  import dct_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [ADDR_W-1:0]             addr,
  input logic [TMR_W-1:0]              wrData,
  input logic [TMR_W-1:0]              rdData,
  input logic                          tick,
  input logic [NUM_TMR-1:0][TMR_W-1:0] cntQ,
  input logic [NUM_TMR-1:0]            atLast,
  input logic [NUM_TMR-1:0]            enQ,
  input logic [NUM_TMR-1:0]            contQ,
  input logic [NUM_TMR-1:0]            stepQ
);
  // R2
  en_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'b000 && !wrData[PERMIT_BIT] && !enQ[0]) |=> !enQ[0]);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && enQ[0] && contQ[0] && tick && atLast[0]) |=> (cntQ[0] == '0));

  // R7
  oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && enQ[0] && !contQ[0] && tick && atLast[0]) |=> (!enQ[0] && $stable(cntQ[0])));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'b001) |=> (cntQ[0] == $past(wrData)));

  // R6
  cascade_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ[1] && !tick) |-> (stepQ[0] && atLast[0]));

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] == 2'd3) |-> (rdData == '0));
endmodule

bind dual_cascade_timer dual_cascade_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .tick(tick), .cntQ(cntQ), .atLast(atLast),
  .enQ(enVec), .contQ(contVec), .stepQ(stepQ)
);

// File: tb/dual_cascade_timer_tb.sv
module dual_cascade_timer_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;

  always #2.5 clk = ~clk;

  dual_cascade_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  int    nChk = 0;
  int    nFail = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int mCnt[2], mMax[2], mEn[2], mCont[2], mPresc[2], mRetrig[2];
  int mDiv;

  function automatic int expRead(logic [2:0] a);
    int t;
    t = int'(a[2]);
    case (a[1:0])
      2'd0: return (mEn[t] << 15) | (mRetrig[t] << 4) | (mPresc[t] << 3) | mCont[t];
      2'd1: return mCnt[t];
      2'd2: return mMax[t];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int tk, t, lastV;
    int stp[2], at[2], nCnt[2], nEn[2];
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mCnt[i] = 0; mMax[i] = 0; mEn[i] = 0;
        mCont[i] = 0; mPresc[i] = 0; mRetrig[i] = 0;
      end
      mDiv = 0;
    end else begin
      tk = (mDiv == 3) ? 1 : 0;
      mDiv = (mDiv + 1) % 4;
      for (int i = 0; i < 2; i++) begin
        lastV = (mMax[i] == 0) ? 65535 : mMax[i] - 1;
        at[i] = (mCnt[i] == lastV) ? 1 : 0;
      end
      stp[0] = (mEn[0] != 0 && tk != 0) ? 1 : 0;
      if (mPresc[1] != 0) stp[1] = (mEn[1] != 0 && stp[0] != 0 && at[0] != 0) ? 1 : 0;
      else                stp[1] = (mEn[1] != 0 && tk != 0) ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        nCnt[i] = mCnt[i];
        nEn[i]  = mEn[i];
        if (stp[i] != 0) begin
          if (at[i] == 0)        nCnt[i] = mCnt[i] + 1;
          else if (mCont[i] != 0) nCnt[i] = 0;
          else                   nEn[i] = 0;
        end
      end
      if (wrEn) begin
        t = int'(addr[2]);
        case (addr[1:0])
          2'd0: begin
            mCont[t]   = int'(wrData[0]);
            mPresc[t]  = int'(wrData[3]);
            mRetrig[t] = int'(wrData[4]);
            if (wrData[14]) nEn[t] = int'(wrData[15]);
          end
          2'd1: nCnt[t] = int'(wrData);
          2'd2: mMax[t] = int'(wrData);
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        mCnt[i] = nCnt[i];
        mEn[i]  = nEn[i];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  // compare the addressed register in every cycle, away from the edges
  always @(negedge clk) begin
    #1;
    if (rstN && !done) chk(curReq, int'(rdData), expRead(addr));
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic watch(logic [2:0] a, int n);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    // R1: reads during reset are zero
    repeat (2) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #0.5;
      chk("R1", int'(rdData), 0);
    end
    rstN = 1'b1;
    curReq = "R1";
    for (int a = 0; a < 8; a++) watch(3'(a), 1);

    // R2: enable without permit is not taken, mode bits are
    curReq = "R2";
    wr(3'b000, 16'h8001);
    watch(3'b000, 3);
    wr(3'b000, 16'h4019);
    watch(3'b000, 3);

    // R8: count and max-compare loads
    curReq = "R8";
    wr(3'b001, 16'd5);
    watch(3'b001, 2);
    wr(3'b010, 16'd4);
    watch(3'b010, 2);
    wr(3'b001, 16'd0);

    // R3 / R9: counter 0 ticks every fourth edge despite its cascade bit
    curReq = "R9";
    wr(3'b000, 16'hC009);
    watch(3'b000, 2);
    curReq = "R3";
    watch(3'b001, 16);
    // R4: continuous wrap at max-compare minus one
    curReq = "R4";
    watch(3'b001, 40);
    // R2: a write without permit leaves a running counter enabled
    curReq = "R2";
    wr(3'b000, 16'h0001);
    watch(3'b000, 3);
    watch(3'b001, 8);

    // R6: counter 1 cascaded on the wrap of counter 0
    curReq = "R6";
    wr(3'b110, 16'd0);
    wr(3'b101, 16'd0);
    wr(3'b100, 16'hC009);
    watch(3'b101, 70);
    // R3: counter 1 counting raw ticks
    curReq = "R3";
    wr(3'b100, 16'hC001);
    watch(3'b101, 20);

    // R8: repeated loads take precedence over stepping
    curReq = "R8";
    for (int k = 0; k < 6; k++) wr(3'b001, 16'd2);
    watch(3'b001, 4);

    // R5: full-range period with max-compare 0, cascade wrap seen on counter 1
    curReq = "R5";
    wr(3'b000, 16'h4001);
    wr(3'b010, 16'd0);
    wr(3'b001, 16'd65533);
    wr(3'b101, 16'd7);
    wr(3'b100, 16'hC009);
    wr(3'b000, 16'hC001);
    watch(3'b001, 20);
    curReq = "R6";
    watch(3'b101, 4);

    // R7: one-shot halts at terminal value and drops its enable
    curReq = "R7";
    wr(3'b000, 16'h4000);
    wr(3'b010, 16'd3);
    wr(3'b001, 16'd0);
    wr(3'b000, 16'h8000 | 16'h4000);
    watch(3'b001, 30);
    watch(3'b000, 3);

    // R10: unmapped index reads zero and writes to it change nothing
    curReq = "R10";
    wr(3'b011, 16'hFFFF);
    wr(3'b111, 16'hFFFF);
    for (int a = 0; a < 8; a++) watch(3'(a), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule